// File: doc/BRIEF.md
# Priority Interrupt Request Arbiter

The block holds a bank of interrupt request nodes. Each node keeps a pending flag, an enable, an 8-bit priority number and a selector that names the service provider it is routed to. Provider 0 is the CPU and provider 1 is the DMA engine. For every provider the block compares all eligible pending nodes each cycle. It presents the winning priority number, not a node index, together with a valid flag.

Requests come in on a per-node set vector. Software changes node state through a simple write port that can write the configuration, set the pending flag or clear it. A provider that accepts a request returns an acknowledge with the priority it took. That acknowledge clears the pending flag of the node holding that priority on that provider.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While reset is asserted and right after it, every provider's valid output is 0 and its priority output is 0. All pending flags, enables and priorities reset to 0.
- R2: A node is eligible for a provider when it is pending and enabled, its selector equals that provider and its priority is nonzero. Among eligible nodes the highest priority is output with valid 1. The output is registered, so a request sampled at clock edge k is visible after edge k+1.
- R3: A node counts only for the provider its selector names (0 = CPU, output bits [7:0]; 1 = DMA, output bits [15:8]).
- R4: A node with priority 0, or with its enable at 0, never wins, even while it is pending.
- R5: When a provider has no eligible node, its valid output is 0 and its priority output reads 0.
- R6: If several eligible nodes on one provider share a priority, the lowest-indexed node is the winner. An acknowledge of that priority clears only that one node.
- R7: An acknowledge on provider p carrying priority v clears the pending flag of the eligible node on p with priority v. An acknowledge whose priority no eligible node on p holds has no effect, including on nodes routed to the other provider.
- R8: Write op 1 sets and op 2 clears the addressed node's pending flag. Op 3 does nothing. Either change is visible in the output one edge after the write edge.
- R9: When a set (request or op 1) and a clear (acknowledge or op 2) hit the same node in the same cycle, the node stays pending.
- R10: Write op 0 loads priority, selector and enable for the addressed node and leaves its pending flag untouched. A changed priority on a pending node reorders the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_NODES | Per-node request, sets pending |
| cfg_we_i | input | 1 | Write strobe |
| cfg_node_i | input | NODE_W | Addressed node |
| cfg_op_i | input | 2 | 0 config, 1 set pending, 2 clear pending, 3 none |
| cfg_prio_i | input | 8 | Priority for op 0 |
| cfg_prov_i | input | PROV_W | Provider selector for op 0 |
| cfg_en_i | input | 1 | Enable for op 0 |
| ack_i | input | NUM_PROV | Per-provider acknowledge strobe |
| ack_prio_i | input | NUM_PROV*8 | Accepted priority, one byte per provider |
| win_prio_o | output | NUM_PROV*8 | Winning priority, one byte per provider |
| win_valid_o | output | NUM_PROV | Winner valid per provider |

## Verification
A new request and an acknowledge can hit the same node in the same cycle, and so can a software clear and a request. The bench makes a node pending, then drives the request and the acknowledge of that node's priority on one edge. It expects the provider to still show that priority as valid two edges later. A following lone acknowledge must then empty the provider, which shows that the earlier clear was really overridden and not simply ignored.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned PRIO_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef enum logic [1:0] {
    OP_CFG = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_NOP = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/irq_node_regs.sv
module irq_node_regs
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_NODES = 16,
  parameter int unsigned PROV_W    = 1
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_NODES-1:0]               cfg_wr_i,
  input  prio_t                              cfg_prio_i,
  input  logic [PROV_W-1:0]                  cfg_prov_i,
  input  logic                               cfg_en_i,
  input  logic [NUM_NODES-1:0]               set_i,
  input  logic [NUM_NODES-1:0]               clr_i,
  output logic [NUM_NODES-1:0][PRIO_W-1:0]   prio_o,
  output logic [NUM_NODES-1:0][PROV_W-1:0]   prov_o,
  output logic [NUM_NODES-1:0]               en_o,
  output logic [NUM_NODES-1:0]               pend_o
);

  for (genvar i = 0; i < NUM_NODES; i++) begin : g_node
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[i] <= '0;
        prov_o[i] <= '0;
        en_o[i]   <= 1'b0;
      end else if (cfg_wr_i[i]) begin
        prio_o[i] <= cfg_prio_i;
        prov_o[i] <= cfg_prov_i;
        en_o[i]   <= cfg_en_i;
      end
    end

    // set dominates clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_o[i] <= 1'b0;
      else if (set_i[i])  pend_o[i] <= 1'b1;
      else if (clr_i[i])  pend_o[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_o[i]); // R9
    AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !pend_o[i]); // R7
    AST_CFG_KEEPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_wr_i[i] && !set_i[i] && !clr_i[i]) |=> (pend_o[i] == $past(pend_o[i]))); // R10
  end

endmodule

// File: rtl/irq_prov_arb.sv
module irq_prov_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_NODES = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_NODES-1:0]             elig_i,
  input  logic [NUM_NODES-1:0][PRIO_W-1:0] prio_i,
  output prio_t                            win_prio_o,
  output logic                             win_valid_o
);

  prio_t best;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best = '0;
    for (int i = 0; i < NUM_NODES; i++) begin
      if (elig_i[i] && (prio_i[i] > best)) best = prio_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_prio_o  <= '0;
      win_valid_o <= 1'b0;
    end else begin
      win_prio_o  <= best;
      win_valid_o <= |elig_i;
    end
  end

  AST_VALID_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (win_prio_o != '0)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_valid_o |-> (win_prio_o == '0)); // R5
  AST_VALID_FROM_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> $past(|elig_i)); // R2

endmodule

// File: rtl/irq_ack_match.sv
module irq_ack_match
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_NODES = 16
) (
  input  logic [NUM_NODES-1:0]             elig_i,
  input  logic [NUM_NODES-1:0][PRIO_W-1:0] prio_i,
  input  logic                             ack_i,
  input  prio_t                            ack_prio_i,
  output logic [NUM_NODES-1:0]             clr_o
);

  logic [NUM_NODES-1:0] hit;

  always_comb begin
    for (int i = 0; i < NUM_NODES; i++) begin
      hit[i] = ack_i && elig_i[i] && (prio_i[i] == ack_prio_i);
    end
  end

  // isolate lowest set bit: same node the arbiter picked on a tie
  assign clr_o = hit & (~hit + {{(NUM_NODES-1){1'b0}}, 1'b1});

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_NODES = 16,
  parameter int unsigned NUM_PROV  = 2,
  localparam int unsigned NODE_W   = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
  localparam int unsigned PROV_W   = (NUM_PROV > 1) ? $clog2(NUM_PROV) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_NODES-1:0]       req_i,
  input  logic                       cfg_we_i,
  input  logic [NODE_W-1:0]          cfg_node_i,
  input  logic [1:0]                 cfg_op_i,
  input  logic [PRIO_W-1:0]          cfg_prio_i,
  input  logic [PROV_W-1:0]          cfg_prov_i,
  input  logic                       cfg_en_i,
  input  logic [NUM_PROV-1:0]        ack_i,
  input  logic [NUM_PROV*PRIO_W-1:0] ack_prio_i,
  output logic [NUM_PROV*PRIO_W-1:0] win_prio_o,
  output logic [NUM_PROV-1:0]        win_valid_o
);

  cfg_op_e op;
  assign op = cfg_op_e'(cfg_op_i);

  logic [NUM_NODES-1:0] cfg_wr, sw_set, sw_clr, set_all, clr_all;
  logic [NUM_NODES-1:0][PRIO_W-1:0] node_prio;
  logic [NUM_NODES-1:0][PROV_W-1:0] node_prov;
  logic [NUM_NODES-1:0] node_en, node_pend;
  logic [NUM_PROV-1:0][NUM_NODES-1:0] elig, ack_clr;

  always_comb begin
    for (int i = 0; i < NUM_NODES; i++) begin
      cfg_wr[i] = cfg_we_i && (cfg_node_i == NODE_W'(i)) && (op == OP_CFG);
      sw_set[i] = cfg_we_i && (cfg_node_i == NODE_W'(i)) && (op == OP_SET);
      sw_clr[i] = cfg_we_i && (cfg_node_i == NODE_W'(i)) && (op == OP_CLR);
    end
  end

  always_comb begin
    clr_all = sw_clr;
    for (int p = 0; p < NUM_PROV; p++) clr_all = clr_all | ack_clr[p];
  end

  assign set_all = req_i | sw_set;

  irq_node_regs #(
    .NUM_NODES(NUM_NODES),
    .PROV_W   (PROV_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_wr_i  (cfg_wr),
    .cfg_prio_i(cfg_prio_i),
    .cfg_prov_i(cfg_prov_i),
    .cfg_en_i  (cfg_en_i),
    .set_i     (set_all),
    .clr_i     (clr_all),
    .prio_o    (node_prio),
    .prov_o    (node_prov),
    .en_o      (node_en),
    .pend_o    (node_pend)
  );

  for (genvar p = 0; p < NUM_PROV; p++) begin : g_prov
    for (genvar i = 0; i < NUM_NODES; i++) begin : g_elig
      assign elig[p][i] = node_pend[i] && node_en[i] &&
                          (node_prov[i] == PROV_W'(p)) && (node_prio[i] != '0);
    end

    irq_prov_arb #(
      .NUM_NODES(NUM_NODES)
    ) u_arb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .elig_i     (elig[p]),
      .prio_i     (node_prio),
      .win_prio_o (win_prio_o[p*PRIO_W +: PRIO_W]),
      .win_valid_o(win_valid_o[p])
    );

    irq_ack_match #(
      .NUM_NODES(NUM_NODES)
    ) u_ack (
      .elig_i    (elig[p]),
      .prio_i    (node_prio),
      .ack_i     (ack_i[p]),
      .ack_prio_i(ack_prio_i[p*PRIO_W +: PRIO_W]),
      .clr_o     (ack_clr[p])
    );

    AST_ONE_CLR_PER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(ack_clr[p]) <= 1); // R6
    AST_NO_ACK_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ack_i[p] |-> (ack_clr[p] == '0)); // R7
  end

endmodule

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_node_i = '0;
  logic [1:0]  cfg_op_i = 2'd3;
  logic [7:0]  cfg_prio_i = '0;
  logic [0:0]  cfg_prov_i = '0;
  logic        cfg_en_i = 1'b0;
  logic [1:0]  ack_i = '0;
  logic [15:0] ack_prio_i = '0;
  logic [15:0] win_prio_o;
  logic [1:0]  win_valid_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_prio_arbiter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
    .cfg_we_i(cfg_we_i), .cfg_node_i(cfg_node_i), .cfg_op_i(cfg_op_i),
    .cfg_prio_i(cfg_prio_i), .cfg_prov_i(cfg_prov_i), .cfg_en_i(cfg_en_i),
    .ack_i(ack_i), .ack_prio_i(ack_prio_i),
    .win_prio_o(win_prio_o), .win_valid_o(win_valid_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // p: 0 cpu, 1 dma
  task automatic chk_prov(string req, int p, int valid, int prio);
    chk(req, int'(win_valid_o[p]), valid);
    chk(req, int'(win_prio_o[p*8 +: 8]), prio);
  endtask

  task automatic settle();
    @(negedge clk_i);
  endtask

  task automatic wr(int node, int op, int prio, int prov, bit en);
    cfg_we_i = 1'b1; cfg_node_i = 4'(node); cfg_op_i = 2'(op);
    cfg_prio_i = 8'(prio); cfg_prov_i = 1'(prov); cfg_en_i = en;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_op_i = 2'd3;
  endtask

  task automatic pulse(logic [N-1:0] mask);
    req_i = mask;
    @(negedge clk_i);
    req_i = '0;
  endtask

  task automatic ack(int p, int prio);
    ack_i[p] = 1'b1; ack_prio_i[p*8 +: 8] = 8'(prio);
    @(negedge clk_i);
    ack_i = '0;
  endtask

  task automatic t_reset();
    chk_prov("R1 cpu in reset", 0, 0, 0);
    chk_prov("R1 dma in reset", 1, 0, 0);
    rst_ni = 1'b1;
    settle();
    chk_prov("R1 cpu after reset", 0, 0, 0);
    chk_prov("R1 dma after reset", 1, 0, 0);
  endtask

  task automatic t_basic();
    wr(2, 0, 40, 0, 1);
    wr(5, 0, 90, 0, 1);
    wr(7, 0, 200, 1, 1);
    pulse(N'((1 << 2) | (1 << 5) | (1 << 7)));
    chk("R2 latency one edge", int'(win_valid_o[0]), 0);
    settle();
    chk_prov("R2 cpu highest", 0, 1, 90);
    chk_prov("R3 dma routed", 1, 1, 200);
    ack(0, 200); settle();
    chk_prov("R7 foreign prio on cpu no effect", 1, 1, 200);
    chk_prov("R7 cpu unchanged", 0, 1, 90);
    ack(0, 90); settle();
    chk_prov("R7 cpu next winner", 0, 1, 40);
    ack(1, 200); settle();
    chk_prov("R5 dma idle", 1, 0, 0);
    ack(0, 40); settle();
    chk_prov("R5 cpu idle", 0, 0, 0);
  endtask

  task automatic t_zero();
    wr(3, 0, 0, 0, 1);
    wr(4, 0, 150, 0, 0);
    pulse(N'((1 << 3) | (1 << 4))); settle();
    chk_prov("R4 prio0 and disabled lose", 0, 0, 0);
    wr(4, 0, 150, 0, 1); settle();
    chk_prov("R10 enable keeps pending", 0, 1, 150);
    wr(4, 2, 0, 0, 0); settle();
    chk_prov("R4 prio0 pending still idle", 0, 0, 0);
    wr(3, 2, 0, 0, 0);
  endtask

  task automatic t_tie();
    wr(9, 0, 77, 0, 1);
    wr(11, 0, 77, 0, 1);
    pulse(N'((1 << 9) | (1 << 11))); settle();
    chk_prov("R6 tie shows prio", 0, 1, 77);
    ack(0, 77); settle();
    chk_prov("R6 ack clears one node", 0, 1, 77);
    ack(0, 77); settle();
    chk_prov("R6 second ack empties", 0, 0, 0);
  endtask

  task automatic t_sw();
    wr(9, 1, 0, 0, 0);
    chk("R8 set not yet visible", int'(win_valid_o[0]), 0);
    settle();
    chk_prov("R8 sw set", 0, 1, 77);
    wr(9, 3, 0, 0, 0); settle();
    chk_prov("R8 op3 no effect", 0, 1, 77);
    wr(9, 2, 0, 0, 0); settle();
    chk_prov("R8 sw clear", 0, 0, 0);
  endtask

  task automatic t_collide();
    wr(9, 1, 0, 0, 0); settle();
    chk_prov("R9 setup", 0, 1, 77);
    req_i[9] = 1'b1; ack_i[0] = 1'b1; ack_prio_i[7:0] = 8'd77;
    @(negedge clk_i);
    req_i = '0; ack_i = '0;
    settle();
    chk_prov("R9 set beats ack", 0, 1, 77);
    ack(0, 77); settle();
    chk_prov("R9 lone ack clears", 0, 0, 0);
    wr(9, 1, 0, 0, 0);
    wr(5, 1, 0, 0, 0);
    wr(9, 0, 120, 0, 1); settle();
    chk_prov("R10 reprioritised wins", 0, 1, 120);
    wr(9, 0, 60, 0, 1); settle();
    chk_prov("R10 lowered loses", 0, 1, 90);
    wr(9, 2, 0, 0, 0);
    wr(5, 2, 0, 0, 0); settle();
    chk_prov("R8 both cleared", 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_basic();
    t_zero();
    t_tie();
    t_sw();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule